// File: doc/BRIEF.md
# ATA Task-File Window Decoder

This block sits on the common-memory and I/O side of a removable disk card. A host access arrives as an offset, a direction and a data word. The block converts the offset into one of sixteen ATA task-file register indices. The conversion depends on a two-bit addressing mode taken from the card's option register. Four modes are supported. One is a memory window, in which a whole kilobyte aliases the data port. One is a contiguous 16-register I/O block. The other two fold the legacy primary or secondary command and control ranges onto the single window.

After the index is known, some accesses are answered locally and the rest are passed on. The local part is the odd-byte data latch, device-control storage with its soft-reset request, the alternate-status readback and the device-address readback. All other accesses are forwarded to a downstream task-file port as one single-cycle read or write strobe. The data port is always forwarded as a full 16-bit word. When the card is powered down, a write to an ordinary task-file register also raises a wake pulse.

Requests are registered once, which drives the strobes. Read data is registered a second time, so it returns a fixed two cycles after the request.

Top module: `ata_window_dec`

## Requirements
- R1: In mode 0 (memory window) an offset from 0x400 through 0x7FF selects index 0. Any other offset passes through unchanged. In every mode the index is the low four bits of the resulting offset.
- R2: In mode 1 (contiguous I/O) the index is the offset modulo 16.
- R3: In mode 2 (primary I/O) an offset in 0x1F0–0x1FF is reduced by 0x1F0, an offset in 0x3F0–0x3FF is reduced by 0x3E8, and any other offset passes through unchanged.
- R4: In mode 3 (secondary I/O) an offset in 0x170–0x17F is reduced by 0x170, an offset in 0x370–0x37F is reduced by 0x368, and any other offset passes through unchanged.
- R5: Index 0x0 and index 0x8 are forwarded as a word access to downstream index 0, with `tf_word` high. A read returns the full 16-bit downstream value.
- R6: The first write to index 0x9 stores the low byte. The second write forwards the word {second byte, first byte} to downstream index 0 as a word write. A read of 0x9 returns the most recent second byte in bits 7:0, with zeros above. After reset that value is 0.
- R7: Index 0xD is forwarded as downstream index 1, for both reads and writes.
- R8: A read of index 0xE returns `drv_status` when `drv_present` is high and 0 otherwise. It produces no strobe.
- R9: A write to index 0xE stores the low byte on `devctl` one cycle after the request. When bit 2 of that byte is set, `srst_req` pulses for exactly that cycle. No strobe is produced.
- R10: A read of index 0xF returns 0xC2 OR ((NOT `drv_sel`) shifted left by 2, masked with 0x3C). It produces no strobe.
- R11: A write to any other index is forwarded unchanged. `wake` is high in the same cycle as its strobe if `pwrdn` was high at the request. Data-port, byte, error/features and control writes never raise `wake`.
- R12: Each forwarded access gives exactly one single-cycle strobe, in the cycle after the request. `tf_rd` and `tf_wr` are never high together. Every read raises `host_rvalid` for one cycle, two cycles after the request.
- R13: After reset no strobe, `wake`, `srst_req` or `host_rvalid` is active, and `devctl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access valid this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | Read data valid |
| mode | input | 2 | Addressing mode field |
| drv_sel | input | 4 | Drive-select value |
| drv_present | input | 1 | A drive is attached |
| drv_status | input | 8 | Drive status byte |
| pwrdn | input | 1 | Card is powered down |
| wake | output | 1 | Clear power-down, set card-ready |
| tf_rd | output | 1 | Downstream read strobe |
| tf_wr | output | 1 | Downstream write strobe |
| tf_idx | output | 4 | Downstream register index |
| tf_word | output | 1 | Access is a 16-bit data word |
| tf_wdata | output | 16 | Downstream write data |
| tf_rdata | input | 16 | Downstream read data, valid with tf_rd |
| devctl | output | 8 | Stored device-control byte |
| srst_req | output | 1 | Soft-reset request pulse |

## Verification
A request sampled at clock edge k drives its strobe, `wake`, `devctl` and `srst_req` between edges k and k+1. Its read data is valid between edges k+1 and k+2. The driver applies stimulus at falling edges. For each request it queues the expected strobe and the expected read result. A monitor samples both queues at each falling edge, so it looks half a cycle after the register that produced the value. The control outputs are checked by the driver at the first falling edge after the request. The pulse is checked again one edge later to confirm that it has dropped.

// File: rtl/ata_win_pkg.sv
`timescale 1ns/1ps
package ata_win_pkg;
  localparam int IDX_W  = 4;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 4;

  localparam logic [IDX_W-1:0] IX_DATA    = 4'h0;
  localparam logic [IDX_W-1:0] IX_DATA_HI = 4'h8;
  localparam logic [IDX_W-1:0] IX_ODD     = 4'h9;
  localparam logic [IDX_W-1:0] IX_ERRFEAT = 4'hd;
  localparam logic [IDX_W-1:0] IX_CTLSTAT = 4'he;
  localparam logic [IDX_W-1:0] IX_DEVADR  = 4'hf;
  localparam logic [IDX_W-1:0] IX_TF_ERR  = 4'h1;

  localparam logic [15:0] PRI_CMD = 16'h01f0;
  localparam logic [15:0] PRI_CTL = 16'h03f0;
  localparam logic [15:0] PRI_ADJ = 16'h03e8;
  localparam logic [15:0] SEC_CMD = 16'h0170;
  localparam logic [15:0] SEC_CTL = 16'h0370;
  localparam logic [15:0] SEC_ADJ = 16'h0368;

  typedef enum logic [1:0] {
    AM_MEMWIN = 2'd0,
    AM_IO16   = 2'd1,
    AM_PRI    = 2'd2,
    AM_SEC    = 2'd3
  } amode_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [IDX_W-1:0]  idx;
    logic              word;
    logic [WORD_W-1:0] wdata;
    logic              wake;
  } fwd_t;

  typedef struct packed {
    logic              valid;
    logic [WORD_W-1:0] data;
  } locrd_t;

  // same 16-byte block (offset bits above 3 equal)
  function automatic logic same_block(input logic [15:0] a, input logic [15:0] base);
    return a[15:4] == base[15:4];
  endfunction

  // offset -> task-file index for a given addressing mode
  function automatic logic [IDX_W-1:0] window_index(input amode_e m, input logic [15:0] a);
    logic [15:0] off;
    off = a;
    case (m)
      AM_MEMWIN: if (a[15:10] == 6'b000001) off = 16'h0000;
      AM_IO16:   off = a & 16'h000f;
      AM_PRI: begin
        if (same_block(a, PRI_CTL))      off = a - PRI_ADJ;
        else if (same_block(a, PRI_CMD)) off = a - PRI_CMD;
      end
      AM_SEC: begin
        if (same_block(a, SEC_CTL))      off = a - SEC_ADJ;
        else if (same_block(a, SEC_CMD)) off = a - SEC_CMD;
      end
      default: off = a;
    endcase
    return off[IDX_W-1:0];
  endfunction

  // device-address byte synthesized from the drive-select value
  function automatic logic [7:0] devaddr_byte(input logic [SEL_W-1:0] sel);
    return 8'hc2 | {2'b00, ~sel, 2'b00};
  endfunction
endpackage

// File: rtl/ata_win_remap.sv
`timescale 1ns/1ps
module ata_win_remap
  import ata_win_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int PAD_W = 16 - ADDR_W;

  logic [15:0] addr16;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr16 = {{PAD_W{1'b0}}, addr};
    end else begin : g_nopad
      assign addr16 = addr[15:0];
    end
  endgenerate

  always_comb idx = window_index(amode_e'(mode), addr16);
endmodule

// File: rtl/ata_win_decode.sv
`timescale 1ns/1ps
module ata_win_decode
  import ata_win_pkg::*;
(
  input  logic              req,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pwrdn,
  input  logic              byte_flag,
  input  logic [7:0]        latch_lo,
  input  logic [7:0]        latch_hi,
  input  logic              drv_present,
  input  logic [7:0]        drv_status,
  input  logic [SEL_W-1:0]  drv_sel,
  output fwd_t              fwd,
  output locrd_t            loc,
  output logic              ctl_wr,
  output logic              byte_lo_wr,
  output logic              byte_hi_wr
);
  always_comb begin
    fwd        = '0;
    loc        = '0;
    ctl_wr     = 1'b0;
    byte_lo_wr = 1'b0;
    byte_hi_wr = 1'b0;
    if (req) begin
      case (idx)
        IX_DATA, IX_DATA_HI: begin
          fwd.rd    = !we;
          fwd.wr    = we;
          fwd.idx   = IX_DATA;
          fwd.word  = 1'b1;
          fwd.wdata = wdata;
        end
        IX_ODD: begin
          if (we) begin
            if (!byte_flag) begin
              byte_lo_wr = 1'b1;
            end else begin
              byte_hi_wr = 1'b1;
              fwd.wr     = 1'b1;
              fwd.idx    = IX_DATA;
              fwd.word   = 1'b1;
              fwd.wdata  = {wdata[7:0], latch_lo};
            end
          end else begin
            loc.valid = 1'b1;
            loc.data  = {8'h00, latch_hi};
          end
        end
        IX_ERRFEAT: begin
          fwd.rd    = !we;
          fwd.wr    = we;
          fwd.idx   = IX_TF_ERR;
          fwd.wdata = wdata;
        end
        IX_CTLSTAT: begin
          if (we) begin
            ctl_wr = 1'b1;
          end else begin
            loc.valid = 1'b1;
            loc.data  = drv_present ? {8'h00, drv_status} : '0;
          end
        end
        default: begin
          if (!we && idx == IX_DEVADR) begin
            loc.valid = 1'b1;
            loc.data  = {8'h00, devaddr_byte(drv_sel)};
          end else begin
            fwd.rd    = !we;
            fwd.wr    = we;
            fwd.idx   = idx;
            fwd.wdata = wdata;
            fwd.wake  = we && pwrdn;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ata_win_local.sv
`timescale 1ns/1ps
module ata_win_local (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_lo_wr,
  input  logic       byte_hi_wr,
  input  logic       ctl_wr,
  input  logic [7:0] wbyte,
  output logic [7:0] latch_lo,
  output logic [7:0] latch_hi,
  output logic       byte_flag,
  output logic [7:0] devctl,
  output logic       srst_req
);
  localparam int SRST_BIT = 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_lo  <= '0;
      latch_hi  <= '0;
      byte_flag <= 1'b0;
    end else begin
      if (byte_lo_wr) begin
        latch_lo  <= wbyte;
        byte_flag <= 1'b1;
      end
      if (byte_hi_wr) begin
        latch_hi  <= wbyte;
        byte_flag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devctl   <= '0;
      srst_req <= 1'b0;
    end else begin
      srst_req <= ctl_wr && wbyte[SRST_BIT];
      if (ctl_wr) devctl <= wbyte;
    end
  end
endmodule

// File: rtl/ata_window_dec.sv
`timescale 1ns/1ps
module ata_window_dec
  import ata_win_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              host_rvalid,
  input  logic [1:0]        mode,
  input  logic [3:0]        drv_sel,
  input  logic              drv_present,
  input  logic [7:0]        drv_status,
  input  logic              pwrdn,
  output logic              wake,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [3:0]        tf_idx,
  output logic              tf_word,
  output logic [15:0]       tf_wdata,
  input  logic [15:0]       tf_rdata,
  output logic [7:0]        devctl,
  output logic              srst_req
);
  logic [IDX_W-1:0] win_idx;
  fwd_t             fwd_d, fwd_q;
  locrd_t           loc_d, loc_q;
  logic             ctl_wr, byte_lo_wr, byte_hi_wr;
  logic [7:0]       latch_lo, latch_hi;
  logic             byte_flag;

  // named events for the checker
  logic ev_fwd;
  logic ev_pair_done;

  ata_win_remap #(.ADDR_W(ADDR_W)) u_remap (
    .mode (mode),
    .addr (host_addr),
    .idx  (win_idx)
  );

  ata_win_decode u_decode (
    .req         (host_req),
    .we          (host_we),
    .idx         (win_idx),
    .wdata       (host_wdata),
    .pwrdn       (pwrdn),
    .byte_flag   (byte_flag),
    .latch_lo    (latch_lo),
    .latch_hi    (latch_hi),
    .drv_present (drv_present),
    .drv_status  (drv_status),
    .drv_sel     (drv_sel),
    .fwd         (fwd_d),
    .loc         (loc_d),
    .ctl_wr      (ctl_wr),
    .byte_lo_wr  (byte_lo_wr),
    .byte_hi_wr  (byte_hi_wr)
  );

  ata_win_local u_local (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_lo_wr (byte_lo_wr),
    .byte_hi_wr (byte_hi_wr),
    .ctl_wr     (ctl_wr),
    .wbyte      (host_wdata[7:0]),
    .latch_lo   (latch_lo),
    .latch_hi   (latch_hi),
    .byte_flag  (byte_flag),
    .devctl     (devctl),
    .srst_req   (srst_req)
  );

  // stage 1: strobes and local read value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q <= '0;
      loc_q <= '0;
    end else begin
      fwd_q <= fwd_d;
      loc_q <= loc_d;
    end
  end

  // stage 2: read return
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= fwd_q.rd || loc_q.valid;
      if (loc_q.valid)   host_rdata <= loc_q.data;
      else if (fwd_q.rd) host_rdata <= tf_rdata;
    end
  end

  assign tf_rd        = fwd_q.rd;
  assign tf_wr        = fwd_q.wr;
  assign tf_idx       = fwd_q.idx;
  assign tf_word      = fwd_q.word;
  assign tf_wdata     = fwd_q.wdata;
  assign wake         = fwd_q.wake;
  assign ev_fwd       = fwd_d.rd || fwd_d.wr;
  assign ev_pair_done = byte_hi_wr;
endmodule

// File: rtl/ata_window_dec_chk.sv
`timescale 1ns/1ps
module ata_window_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_req,
  input logic       host_we,
  input logic       host_rvalid,
  input logic       pwrdn,
  input logic       wake,
  input logic       tf_rd,
  input logic       tf_wr,
  input logic [3:0] tf_idx,
  input logic       tf_word,
  input logic [7:0] devctl,
  input logic       srst_req,
  input logic       byte_flag,
  input logic       ev_fwd,
  input logic       ev_pair_done
);
  p_excl_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tf_rd && tf_wr));

  p_strobe_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fwd |=> (tf_rd || tf_wr));

  p_strobe_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr) |-> $past(host_req));

  p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tf_rd |=> host_rvalid);

  p_srst_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |-> devctl[2]);

  p_wake_fwd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (tf_wr && !tf_word && $past(pwrdn)));

  p_word_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tf_word |-> (tf_idx == 4'h0));

  p_pair_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair_done |=> (tf_wr && tf_word && !byte_flag));

  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_flag) |-> $past(host_req && host_we));
endmodule

bind ata_window_dec ata_window_dec_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_req     (host_req),
  .host_we      (host_we),
  .host_rvalid  (host_rvalid),
  .pwrdn        (pwrdn),
  .wake         (wake),
  .tf_rd        (tf_rd),
  .tf_wr        (tf_wr),
  .tf_idx       (tf_idx),
  .tf_word      (tf_word),
  .devctl       (devctl),
  .srst_req     (srst_req),
  .byte_flag    (byte_flag),
  .ev_fwd       (ev_fwd),
  .ev_pair_done (ev_pair_done)
);

// File: tb/ata_window_dec_bench.sv
`timescale 1ns/1ps
module ata_window_dec_bench;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic          host_rvalid;
  logic [1:0]    mode = 2'd0;
  logic [3:0]    drv_sel = 4'h0;
  logic          drv_present = 1'b1;
  logic [7:0]    drv_status = 8'h50;
  logic          pwrdn = 1'b0;
  logic          wake, tf_rd, tf_wr, tf_word, srst_req;
  logic [3:0]    tf_idx;
  logic [15:0]   tf_wdata, tf_rdata;
  logic [7:0]    devctl;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // downstream model
  assign tf_rdata = {8'ha5, 4'h0, tf_idx};

  ata_window_dec #(.ADDR_W(AW)) u_ata_window_dec (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mode(mode), .drv_sel(drv_sel),
    .drv_present(drv_present), .drv_status(drv_status), .pwrdn(pwrdn),
    .wake(wake), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_idx(tf_idx),
    .tf_word(tf_word), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
    .devctl(devctl), .srst_req(srst_req)
  );

  typedef struct {
    logic        wr;
    logic [3:0]  idx;
    logic        word;
    logic [15:0] wdata;
    logic        wake;
    string       tag;
  } sexp_t;

  typedef struct {
    logic [15:0] d;
    string       tag;
  } rexp_t;

  sexp_t sq[$];
  rexp_t rq[$];

  // bench-side byte pairing model
  logic       m_flag = 1'b0;
  logic [7:0] m_lo = 8'h00, m_hi = 8'h00;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_idx(input logic [1:0] m, input int a);
    int o;
    o = a;
    if (m == 2'd0) begin
      if (a >= 'h400 && a <= 'h7ff) o = 0;
    end else if (m == 2'd1) begin
      o = a % 16;
    end else if (m == 2'd2) begin
      if (a >= 'h1f0 && a <= 'h1ff) o = a - 'h1f0;
      else if (a >= 'h3f0 && a <= 'h3ff) o = a - 'h3e8;
    end else begin
      if (a >= 'h170 && a <= 'h17f) o = a - 'h170;
      else if (a >= 'h370 && a <= 'h37f) o = a - 'h368;
    end
    return 4'(o % 16);
  endfunction

  task automatic push_s(input logic wr, input logic [3:0] ix, input logic wd,
                        input logic [15:0] d, input logic wk, input string tag);
    sexp_t s;
    s.wr = wr; s.idx = ix; s.word = wd; s.wdata = d; s.wake = wk; s.tag = tag;
    sq.push_back(s);
  endtask

  task automatic push_r(input logic [15:0] d, input string tag);
    rexp_t r;
    r.d = d; r.tag = tag;
    rq.push_back(r);
  endtask

  // driver: applies one access and queues what it must produce
  task automatic acc(input logic we, input int a, input logic [15:0] d, input string tag);
    logic [3:0] ix;
    ix = exp_idx(mode, a);
    if (ix == 4'h0 || ix == 4'h8) begin
      push_s(we, 4'h0, 1'b1, d, 1'b0, tag);
      if (!we) push_r(16'ha500, tag);
    end else if (ix == 4'h9) begin
      if (we) begin
        if (!m_flag) begin
          m_lo = d[7:0]; m_flag = 1'b1;
        end else begin
          m_hi = d[7:0]; m_flag = 1'b0;
          push_s(1'b1, 4'h0, 1'b1, {m_hi, m_lo}, 1'b0, tag);
        end
      end else push_r({8'h00, m_hi}, tag);
    end else if (ix == 4'hd) begin
      push_s(we, 4'h1, 1'b0, d, 1'b0, tag);
      if (!we) push_r(16'ha501, tag);
    end else if (ix == 4'he) begin
      if (!we) push_r(drv_present ? {8'h00, drv_status} : 16'h0000, tag);
    end else if (ix == 4'hf && !we) begin
      push_r({8'h00, 8'hc2 | ((8'(~drv_sel) & 8'h0f) << 2)}, tag);
    end else begin
      push_s(we, ix, 1'b0, d, we & pwrdn, tag);
      if (!we) push_r(16'ha500 | {12'h000, ix}, tag);
    end
    host_req = 1'b1; host_we = we; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares design results against the queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (tf_rd || tf_wr) begin
        if (sq.size() == 0) begin
          check("R12 unexpected strobe", 32'(tf_idx), 32'hffff);
        end else begin
          sexp_t s;
          s = sq.pop_front();
          check({s.tag, " strobe"}, {tf_wr, tf_rd, tf_word, tf_idx, wake},
                {s.wr, !s.wr, s.word, s.idx, s.wake});
          if (s.wr) check({s.tag, " wdata"}, 32'(tf_wdata), 32'(s.wdata));
        end
      end else if (wake) begin
        check("R11 wake without write", 32'(wake), 32'h0);
      end
      if (host_rvalid) begin
        if (rq.size() == 0) begin
          check("R12 unexpected rvalid", 32'(host_rdata), 32'hffff);
        end else begin
          rexp_t r;
          r = rq.pop_front();
          check({r.tag, " rdata"}, 32'(host_rdata), 32'(r.d));
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 reset outputs", {tf_rd, tf_wr, wake, srst_req, host_rvalid}, 5'b0);
    check("R13 reset devctl", 32'(devctl), 32'h0);

    // R1 memory window
    mode = 2'd0;
    acc(1'b0, 'h400, 16'h0, "R1 low edge");
    acc(1'b0, 'h7fe, 16'h0, "R1 high edge");
    acc(1'b0, 'h123, 16'h0, "R1 passthrough");
    acc(1'b0, 'h3ff, 16'h0, "R1 below window");
    acc(1'b1, 'h008, 16'hbeef, "R5 alt data write");

    // R2 contiguous I/O
    mode = 2'd1;
    acc(1'b1, 'h035, 16'h00ab, "R2 write");
    acc(1'b0, 'h02d, 16'h0, "R7 error read");
    acc(1'b1, 'h0fd, 16'h0077, "R7 features write");
    acc(1'b0, 'h000, 16'h0, "R5 data read");
    drv_sel = 4'h0; acc(1'b0, 'h01f, 16'h0, "R10 sel0");
    drv_sel = 4'h1; acc(1'b0, 'h00f, 16'h0, "R10 sel1");
    drv_sel = 4'ha; acc(1'b0, 'h04f, 16'h0, "R10 sel a");

    // R6 byte pairing
    acc(1'b0, 'h009, 16'h0, "R6 read after reset");
    acc(1'b1, 'h009, 16'h0034, "R6 low byte");
    acc(1'b1, 'h009, 16'h0012, "R6 high byte");
    acc(1'b0, 'h019, 16'h0, "R6 readback");

    // R3 primary
    mode = 2'd2;
    acc(1'b0, 'h1f7, 16'h0, "R3 command block");
    drv_present = 1'b1; drv_status = 8'h58;
    acc(1'b0, 'h3f6, 16'h0, "R8 status present");
    drv_present = 1'b0;
    acc(1'b0, 'h3f6, 16'h0, "R8 status absent");
    drv_present = 1'b1;
    acc(1'b0, 'h3f7, 16'h0, "R3 control block devaddr");
    acc(1'b0, 'h055, 16'h0, "R3 passthrough");
    acc(1'b0, 'h1f0, 16'h0, "R3 data");

    // R4 secondary
    mode = 2'd3;
    acc(1'b0, 'h170, 16'h0, "R4 data");
    acc(1'b0, 'h17d, 16'h0, "R4 error");
    acc(1'b0, 'h376, 16'h0, "R4 status");
    acc(1'b0, 'h244, 16'h0, "R4 passthrough");

    // R9 device control
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'('h376); host_wdata = 16'h0006;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    check("R9 devctl stored", 32'(devctl), 32'h06);
    check("R9 srst pulse", 32'(srst_req), 32'h1);
    @(negedge clk);
    check("R9 srst single cycle", 32'(srst_req), 32'h0);
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'('h376); host_wdata = 16'h0002;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    check("R9 no srst", {devctl, srst_req}, {8'h02, 1'b0});
    @(negedge clk);

    // R11 wake
    pwrdn = 1'b1;
    acc(1'b1, 'h172, 16'h0011, "R11 wake on task write");
    acc(1'b1, 'h170, 16'h2222, "R11 no wake on data");
    acc(1'b1, 'h17d, 16'h0033, "R11 no wake on features");
    acc(1'b0, 'h173, 16'h0, "R11 no wake on read");
    pwrdn = 1'b0;
    acc(1'b1, 'h174, 16'h0044, "R11 awake write");

    repeat (4) @(negedge clk);
    check("R12 strobe queue drained", 32'(sq.size()), 32'h0);
    check("R12 read queue drained", 32'(rq.size()), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule